// File: doc/BRIEF.md
# Reset Qualification and Power-Up Sequencer

This block turns an external active-low reset pin into the internal synchronous reset of a device that runs from a single reference clock. It tells two kinds of reset apart. A cold start follows the power-on input. In that case internal reset is held until the pin has stayed low long enough for the on-chip clock multiplier to settle. A warm reset arrives during operation and needs only a short minimum pulse. A pulse shorter than that minimum is discarded without any effect.

The pin passes through a two-flop synchronizer. A saturating counter measures how long the synchronized pin stays low, and a small sequencer compares that length against the hold that applies at the time. The sequencer releases internal reset when a qualified assertion ends. One cycle after the release it raises a clock-ready flag for downstream logic, which treats converter and processing clocks as valid only while that flag is high. A settle counter stands in for the multiplier lock indication. With the default reference of 16.9344 MHz, the 150 µs settling time rounds up to a cold hold of 2541 cycles. The warm hold is 16 cycles. Both holds are parameters, and the warm hold must be at least 2 and below the cold hold.

Top module: `rst_qualifier`

## Requirements
- R1: The pin is seen through two synchronizing flops. If the pin is driven low just after clock edge 0, the counter first advances at edge 3, and the measured length equals the number of edges at which the pin was sampled low.
- R2: When not in cold start, a low pulse sampled at fewer than WARM_HOLD edges is ignored: core_rst stays 0 and clk_ready stays 1 throughout.
- R3: When not in cold start, a pin held low for n >= WARM_HOLD edges drives core_rst to 1 from edge WARM_HOLD+2, and clk_ready to 0 at that same edge.
- R4: A qualified pulse that ends with the pin high after edge n releases core_rst (1 to 0) at edge n+3.
- R5: clk_ready goes to 1 exactly one edge after core_rst falls, and is never 1 while core_rst is 1.
- R6: While por is high, the clocked state resets: core_rst=1 and clk_ready=0.
- R7: In cold start the hold is COLD_HOLD. A shorter assertion leaves core_rst at 1 and clk_ready at 0.
- R8: cold_start falls at edge COLD_HOLD+2 of a long enough cold assertion. From then on only WARM_HOLD applies.
- R9: por sets cold_start to 1 at once, without waiting for a clock edge.
- R10: The hold counter saturates at COLD_HOLD and never exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por | input | 1 | Power-on indication, active high. Sets the cold flag asynchronously and resets the other state synchronously |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous to clk |
| core_rst | output | 1 | Internal synchronous reset, active high |
| clk_ready | output | 1 | Internal clocks treated as valid |
| cold_start | output | 1 | Cold-start hold still pending |

## Verification
On every cycle the assertions check several relations. clk_ready and core_rst are never high together. A release is always followed by ready on the next edge. core_rst is held for as long as the cold flag is set, and a new assertion of core_rst can only come from a warm reset. The counter stays within its limit. The exact edge counts from pin change to reset change can only be shown by the bench's scenarios. These include the discarding of short pulses, the cold-hold boundary and the asynchronous effect of por. The bench covers them by sweeping the pulse length across the warm threshold and by trying cold attempts below and exactly at the cold hold.

// File: rtl/rqs_pkg.sv
package rqs_pkg;

    // Result of comparing the next hold count against both thresholds.
    typedef struct packed {
        logic warm_hit;
        logic cold_hit;
    } hold_flags_t;

    function automatic int cnt_bits(input int lim);
        return $clog2(lim + 1);
    endfunction

    function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
        return (v >= lim) ? lim : v + 32'd1;
    endfunction

endpackage

// File: rtl/rqs_sync.sv
module rqs_sync (
    input  logic clk,
    input  logic por,
    input  logic pin_n,
    output logic asserted
);
    logic s1, s2;

    always_ff @(posedge clk) begin
        if (por) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= ~pin_n;
            s2 <= s1;
        end
    end

    assign asserted = s2;
endmodule

// File: rtl/rqs_hold_counter.sv
module rqs_hold_counter #(
    parameter int COLD_HOLD = 2541,
    parameter int WARM_HOLD = 16
) (
    input  logic                      clk,
    input  logic                      por,
    input  logic                      asserted,
    output rqs_pkg::hold_flags_t      flags
);
    localparam int CW = rqs_pkg::cnt_bits(COLD_HOLD);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = CW'(rqs_pkg::sat_inc(32'(cnt), 32'(COLD_HOLD)));
        flags.warm_hit = asserted && (cnt_nxt >= CW'(WARM_HOLD));
        flags.cold_hit = asserted && (cnt_nxt >= CW'(COLD_HOLD));
    end

    always_ff @(posedge clk) begin
        if (por || !asserted) cnt <= '0;
        else                  cnt <= cnt_nxt;
    end

    p_cnt_sat_r10: assert property (@(posedge clk) disable iff (por)
        cnt <= CW'(COLD_HOLD));
endmodule

// File: rtl/rqs_seq.sv
module rqs_seq (
    input  logic                 clk,
    input  logic                 por,
    input  logic                 asserted,
    input  rqs_pkg::hold_flags_t flags,
    output logic                 core_rst,
    output logic                 clk_ready,
    output logic                 cold
);
    logic armed;
    logic core_nxt, armed_nxt;

    always_comb begin
        core_nxt  = core_rst;
        armed_nxt = armed;
        if (asserted) begin
            if (cold ? flags.cold_hit : flags.warm_hit) armed_nxt = 1'b1;
            if (!cold && flags.warm_hit) core_nxt = 1'b1;
        end else if (armed) begin
            armed_nxt = 1'b0;
            core_nxt  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (por) begin
            armed     <= 1'b0;
            core_rst  <= 1'b1;
            clk_ready <= 1'b0;
        end else begin
            armed     <= armed_nxt;
            core_rst  <= core_nxt;
            clk_ready <= !core_rst && !core_nxt;
        end
    end

    // Cold flag: set asynchronously by power-on, cleared once the long hold completes.
    always_ff @(posedge clk or posedge por) begin
        if (por)                              cold <= 1'b1;
        else if (cold && asserted && flags.cold_hit) cold <= 1'b0;
    end

    p_ready_after_release_r5: assert property (@(posedge clk) disable iff (por)
        $fell(core_rst) |=> clk_ready);
    p_ready_exclusive_r5: assert property (@(posedge clk) disable iff (por)
        clk_ready |-> !core_rst);
    p_cold_holds_reset_r7: assert property (@(posedge clk) disable iff (por)
        cold |-> core_rst);
    p_cold_clear_in_reset_r8: assert property (@(posedge clk) disable iff (por)
        $fell(cold) |-> core_rst);
    p_warm_entry_r3: assert property (@(posedge clk) disable iff (por)
        $rose(core_rst) |-> (!cold && $past(asserted)));
endmodule

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
    parameter int COLD_HOLD = 2541,
    parameter int WARM_HOLD = 16
) (
    input  logic clk,
    input  logic por,
    input  logic ext_rst_n,
    output logic core_rst,
    output logic clk_ready,
    output logic cold_start
);
    logic                 asserted;
    rqs_pkg::hold_flags_t flags;

    initial begin
        if (WARM_HOLD < 2 || WARM_HOLD >= COLD_HOLD)
            $error("rst_qualifier: need 2 <= WARM_HOLD < COLD_HOLD");
    end

    rqs_sync u_sync (
        .clk      (clk),
        .por      (por),
        .pin_n    (ext_rst_n),
        .asserted (asserted)
    );

    rqs_hold_counter #(.COLD_HOLD(COLD_HOLD), .WARM_HOLD(WARM_HOLD)) u_cnt (
        .clk      (clk),
        .por      (por),
        .asserted (asserted),
        .flags    (flags)
    );

    rqs_seq u_seq (
        .clk       (clk),
        .por       (por),
        .asserted  (asserted),
        .flags     (flags),
        .core_rst  (core_rst),
        .clk_ready (clk_ready),
        .cold      (cold_start)
    );
endmodule

// File: tb/sim_rst_qualifier.sv
`timescale 1ns/1ps
module sim_rst_qualifier;
    localparam int C = 40;
    localparam int W = 6;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic ext_rst_n = 1'b0;
    logic core_rst, clk_ready, cold_start;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    rst_qualifier #(.COLD_HOLD(C), .WARM_HOLD(W)) u0 (
        .clk(clk), .por(por), .ext_rst_n(ext_rst_n),
        .core_rst(core_rst), .clk_ready(clk_ready), .cold_start(cold_start)
    );

    task automatic check(input string req, input logic act, input logic exp, input int k);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s k=%0d actual=%b expected=%b", req, k, act, exp);
        end
    endtask

    // Warm pulse sampled low at n edges; observed for n+8 edges.
    task automatic warm_case(input int n);
        bit q;
        q = (n >= W);
        @(posedge clk); #2 ext_rst_n = 1'b0;
        for (int k = 1; k <= n + 8; k++) begin
            @(posedge clk); #2;
            check(q ? "R3/R4" : "R2", core_rst, q && k >= W + 2 && k <= n + 2, k);
            check(q ? "R5" : "R2", clk_ready, !(q && k >= W + 2 && k <= n + 3), k);
            check("R1", cold_start, 1'b0, k);
            if (k == n) ext_rst_n = 1'b1;
        end
    endtask

    // Cold attempt: pin low for n edges, starting right after edge 0.
    task automatic cold_case(input int n, input bit from_por);
        bit q;
        q = (n >= C);
        @(posedge clk); #2;
        if (from_por) por = 1'b0;
        ext_rst_n = 1'b0;
        for (int k = 1; k <= n + 8; k++) begin
            @(posedge clk); #2;
            check("R7", core_rst, !(q && k >= n + 3), k);
            check("R5", clk_ready, q && k >= n + 4, k);
            check("R8", cold_start, !(q && k >= C + 2), k);
            if (k == n) ext_rst_n = 1'b1;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R6", core_rst, 1'b1, 0);
        check("R6", clk_ready, 1'b0, 0);
        check("R9", cold_start, 1'b1, 0);
        cold_case(20, 1'b1);     // too short: stays cold
        repeat (4) @(posedge clk);
        cold_case(C, 1'b0);      // exactly the cold hold
        for (int n = 1; n <= W + 4; n++) begin
            warm_case(n);
        end
        warm_case(C + 5);        // long warm pulse, counter saturated
        // Asynchronous power-on mid-operation.
        @(posedge clk); #2 por = 1'b1;
        #1 check("R9", cold_start, 1'b1, 0);
        @(posedge clk); #2;
        check("R6", core_rst, 1'b1, 1);
        check("R6", clk_ready, 1'b0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule